// File: doc/BRIEF.md
# Serial Byte Transmitter with Break Generation

This block serialises bytes onto a single idle-high transmit line. A byte is handed over through a valid/ready handshake and goes out as one low start bit, the data bits least significant first, and a high stop period. The stop period is selectable in half-bit steps from half a bit to two bits. Bit timing comes from an internal divider. A prescale input sets how many system clocks make one oversample tick, and every bit lasts a fixed number of ticks (sixteen by default).

Software can also request a break. The request sets a command flag, and the block then sends a frame that holds the line low through the start, data and stop times, followed by one bit period high. The flag clears itself when that frame is complete. A break requested during a data frame waits for that frame to finish, and then goes ahead of any byte offered at the input. The stop-length setting accepts writes only while the transmit enable is low. Dropping the enable in the middle of a frame lets the frame finish before the block goes quiet.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line is high, the break flag is 0 and the stop code is 00. `in_ready` equals `tx_en` while nothing is being sent.
- R2: A data frame is low for one bit time, then carries data bits 0 to 7 in that order, then is high for the stop time. Every bit time is 16 ticks, and one tick is `prescale`+1 clocks.
- R3: Stop code 00 gives 16 ticks of stop (1 bit), 01 gives 8 (half a bit), 10 gives 32 (2 bits) and 11 gives 24 (1.5 bits).
- R4: `in_ready` is 1 exactly when the block is idle, `tx_en` is 1 and the break flag is 0. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1, and its start bit appears on the line in the following cycle.
- R5: A write strobe `stop_wr` loads `stop_wdata` into the stop code only if `tx_en` was 0 at that edge. Otherwise the code, visible on `stop_code`, is unchanged.
- R6: A break frame holds the line low for the start time, the 8 data times and the stop time, then high for 16 ticks. It begins one edge after the flag is seen while the block is idle and enabled.
- R7: `brk_set` raises the break flag. The flag drops on the edge that ends the break frame. While the flag is 0, no break frame is sent and the idle line stays high.
- R8: A break flag raised during a data frame waits until that frame's stop time ends, and the break frame is sent before a byte that is waiting at the input.
- R9: Clearing `tx_en` during a frame lets that frame run to its end. The block then stays idle with `in_ready` at 0 and ignores `in_valid`.
- R10: The stop length is taken from the stop code at the start of a frame. A code written later during the same frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; also locks the stop code |
| prescale | input | PRE_W | Clocks per oversample tick minus one |
| stop_wr | input | 1 | Stop-code write strobe |
| stop_wdata | input | 2 | Stop code to write |
| stop_code | output | 2 | Current stop code |
| brk_set | input | 1 | Raises the break flag |
| brk_busy | output | 1 | Break flag |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Byte can be taken |
| tx | output | 1 | Serial line, idle high |

## Verification
Results land at fixed distances from the stimulus. A taken byte shows its start bit one cycle after the accepting edge. Each line level then holds for its tick count times `prescale`+1 cycles. A break starts two edges after `brk_set` when the block is idle, a stop-code write shows on the following cycle, and the break flag drops on the same edge that returns the line to idle. The bench keeps a queue of expected line levels, filled when a frame starts and popped on every edge. It compares the line, ready, break flag and stop code in the middle of every clock period. Inputs are driven just after a rising edge, so each edge sees settled values.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_MARK
   } tx_state_e;

   // Stop length in half-bit units for each 2-bit stop code.
   function automatic logic [2:0] stop_halves(input logic [1:0] code);
      case (code)
         2'b00:   return 3'd2;
         2'b01:   return 3'd1;
         2'b10:   return 3'd4;
         default: return 3'd3;
      endcase
   endfunction

endpackage

// File: rtl/uart_brk_tick.sv
module uart_brk_tick #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] prescale,
   output logic             tick
);

   logic [PRE_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt >= prescale);
   assign tick   = run && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || at_end) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/uart_brk_cfg.sv
module uart_brk_cfg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       stop_wr,
   input  logic [1:0] stop_wdata,
   input  logic       brk_req,
   input  logic       brk_done,
   output logic [1:0] stop_code,
   output logic       brk_cmd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              stop_code <= 2'b00;
      else if (stop_wr && !en) stop_code <= stop_wdata;
   end

   // A new request wins over the completion of the previous break.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        brk_cmd <= 1'b0;
      else if (brk_req)  brk_cmd <= 1'b1;
      else if (brk_done) brk_cmd <= 1'b0;
   end

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
   import uart_brk_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              brk_cmd,
   input  logic              tick,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        stop_code,
   output logic              in_ready,
   output logic              tx,
   output logic              run,
   output logic              brk_done
);

   localparam int LEN_W  = $clog2(2 * OVS + 1);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int HALF   = OVS / 2;

   tx_state_e         state;
   logic [LEN_W-1:0]  tcnt;
   logic [LEN_W-1:0]  stop_len;
   logic [LEN_W-1:0]  state_len;
   logic [BIT_W-1:0]  bitcnt;
   logic [DATA_W-1:0] shreg;
   logic              brk_frame;
   logic              last;
   logic              idle;
   logic              start_brk;
   logic              start_dat;
   logic [LEN_W-1:0]  new_stop;

   assign idle      = (state == ST_IDLE);
   assign start_brk = idle && en && brk_cmd;
   assign start_dat = idle && en && !brk_cmd && in_valid;
   assign in_ready  = idle && en && !brk_cmd;
   assign run       = !idle;
   assign new_stop  = LEN_W'(HALF) * LEN_W'(stop_halves(stop_code));

   always_comb begin
      case (state)
         ST_STOP: state_len = stop_len;
         default: state_len = LEN_W'(OVS);
      endcase
   end

   assign last     = (tcnt == state_len - 1'b1);
   assign brk_done = (state == ST_MARK) && tick && last;

   always_comb begin
      case (state)
         ST_START: tx = 1'b0;
         ST_DATA:  tx = !brk_frame && shreg[0];
         ST_STOP:  tx = !brk_frame;
         default:  tx = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tcnt      <= '0;
         bitcnt    <= '0;
         shreg     <= '0;
         brk_frame <= 1'b0;
         stop_len  <= '0;
      end else if (idle) begin
         if (start_brk || start_dat) begin
            state     <= ST_START;
            tcnt      <= '0;
            bitcnt    <= '0;
            brk_frame <= start_brk;
            shreg     <= start_brk ? '0 : in_data;
            stop_len  <= new_stop;
         end
      end else if (tick) begin
         if (!last) begin
            tcnt <= tcnt + 1'b1;
         end else begin
            tcnt <= '0;
            if (state == ST_START) begin
               state <= ST_DATA;
            end else if (state == ST_DATA) begin
               if (bitcnt == BIT_W'(DATA_W - 1)) begin
                  state <= ST_STOP;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
                  shreg  <= shreg >> 1;
               end
            end else if (state == ST_STOP) begin
               state <= brk_frame ? ST_MARK : ST_IDLE;
            end else begin
               state <= ST_IDLE;
            end
         end
      end
   end

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [PRE_W-1:0]  prescale,
   input  logic              stop_wr,
   input  logic [1:0]        stop_wdata,
   output logic [1:0]        stop_code,
   input  logic              brk_set,
   output logic              brk_busy,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              tx
);

   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be an even number of at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("PRE_W must be at least 1");
   end

   logic tick;
   logic run;
   logic brk_done;

   uart_brk_tick #(.PRE_W(PRE_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .prescale (prescale),
      .tick     (tick)
   );

   uart_brk_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tx_en),
      .stop_wr    (stop_wr),
      .stop_wdata (stop_wdata),
      .brk_req    (brk_set),
      .brk_done   (brk_done),
      .stop_code  (stop_code),
      .brk_cmd    (brk_busy)
   );

   uart_brk_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .brk_cmd   (brk_busy),
      .tick      (tick),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .stop_code (stop_code),
      .in_ready  (in_ready),
      .tx        (tx),
      .run       (run),
      .brk_done  (brk_done)
   );

endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_en,
   input logic [1:0] stop_code,
   input logic       brk_busy,
   input logic       in_valid,
   input logic       in_ready,
   input logic       tx
);

   // R1: an idle block that can take a byte holds the line high
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> tx);

   // R4: ready only when enabled and no break is waiting
   a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (tx_en && !brk_busy));

   // R2: a taken byte starts with a low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !tx);

   // R5: stop code frozen while enabled
   a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |=> $stable(stop_code));

   // R7: the break flag drops only as the line returns high
   a_r7_brk_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk_busy) |-> tx);

endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .stop_code (stop_code),
   .brk_busy  (brk_busy),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .tx        (tx)
);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;

   localparam int CLK_T  = 10;
   localparam int OVS    = 16;
   localparam int PRE_W  = 8;
   localparam int WD_MAX = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_en = 1'b0;
   logic [PRE_W-1:0] prescale = 8'd1;
   logic             stop_wr = 1'b0;
   logic [1:0]       stop_wdata = 2'b00;
   logic [1:0]       stop_code;
   logic             brk_set = 1'b0;
   logic             brk_busy;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             in_ready;
   logic             tx;

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   bit m_q[$];
   bit m_brk = 0;
   bit m_cur_brk = 0;
   int m_stop = 0;

   always #(CLK_T/2) clk = ~clk;

   uart_brk_tx #(.DATA_W(8), .OVS(OVS), .PRE_W(PRE_W)) dut (
      .clk (clk), .rst_n (rst_n), .tx_en (tx_en), .prescale (prescale),
      .stop_wr (stop_wr), .stop_wdata (stop_wdata), .stop_code (stop_code),
      .brk_set (brk_set), .brk_busy (brk_busy), .in_valid (in_valid),
      .in_data (in_data), .in_ready (in_ready), .tx (tx)
   );

   function automatic int stop_ticks(int code);
      case (code)
         0: return OVS;
         1: return OVS / 2;
         2: return 2 * OVS;
         default: return 3 * OVS / 2;
      endcase
   endfunction

   function automatic void push_frame(bit [7:0] d, bit b, int code, int p);
      repeat (OVS * p) m_q.push_back(1'b0);
      for (int i = 0; i < 8; i++)
         repeat (OVS * p) m_q.push_back(b ? 1'b0 : d[i]);
      repeat (stop_ticks(code) * p) m_q.push_back(!b);
      if (b) repeat (OVS * p) m_q.push_back(1'b1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_brk = 0;
         m_cur_brk = 0;
         m_stop = 0;
      end else begin
         if (m_q.size() != 0) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0 && m_cur_brk) m_brk = 0;
         end else if (tx_en && m_brk) begin
            push_frame(8'h00, 1'b1, m_stop, int'(prescale) + 1);
            m_cur_brk = 1;
         end else if (tx_en && in_valid) begin
            push_frame(in_data, 1'b0, m_stop, int'(prescale) + 1);
            m_cur_brk = 0;
         end
         if (brk_set) m_brk = 1;
         if (stop_wr && !tx_en) m_stop = int'(stop_wdata);
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // compare on every clock, mid-period
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         chk(tx == (m_q.size() != 0 ? m_q[0] : 1'b1), {cur_req, " tx"}, int'(tx),
             int'(m_q.size() != 0 ? m_q[0] : 1'b1));
         chk(in_ready == (tx_en && m_q.size() == 0 && !m_brk), {cur_req, " ready R4"},
             int'(in_ready), int'(tx_en && m_q.size() == 0 && !m_brk));
         chk(brk_busy == m_brk, {cur_req, " brk R7"}, int'(brk_busy), int'(m_brk));
         chk(int'(stop_code) == m_stop, {cur_req, " stop R5"}, int'(stop_code), m_stop);
      end
      if (cyc > WD_MAX && !done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_MAX);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic send_byte(bit [7:0] d);
      step();
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      step();
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (m_q.size() != 0 || m_brk) @(negedge clk);
   endtask

   task automatic set_stop(int code);
      step();
      tx_en = 1'b0;
      stop_wr = 1'b1;
      stop_wdata = 2'(code);
      step();
      stop_wr = 1'b0;
      tx_en = 1'b1;
   endtask

   initial begin
      int waited;
      repeat (3) step();
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk(tx == 1'b1, "R1 idle line", int'(tx), 1);
      chk(in_ready == 1'b0, "R1 ready off", int'(in_ready), 0);
      chk(brk_busy == 1'b0, "R1 break flag", int'(brk_busy), 0);
      chk(stop_code == 2'b00, "R1 stop code", int'(stop_code), 0);
      step();
      tx_en = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready on enable", int'(in_ready), 1);

      // R5: writes only while disabled
      cur_req = "R5";
      step(); tx_en = 1'b0; stop_wr = 1'b1; stop_wdata = 2'b01;
      step(); stop_wr = 1'b0;
      @(negedge clk);
      chk(stop_code == 2'b01, "R5 write when off", int'(stop_code), 1);
      step(); tx_en = 1'b1;
      step(); stop_wr = 1'b1; stop_wdata = 2'b10;
      step(); stop_wr = 1'b0;
      @(negedge clk);
      chk(stop_code == 2'b01, "R5 write ignored when on", int'(stop_code), 1);

      // R2 R3: frames under every stop code
      cur_req = "R2 R3 code01";
      send_byte(8'hA5); wait_idle();
      cur_req = "R2 R3 code00";
      set_stop(0); prescale = 8'd0;
      send_byte(8'h3C); wait_idle();
      cur_req = "R2 R3 code10";
      set_stop(2); prescale = 8'd2;
      send_byte(8'hC3); wait_idle();
      cur_req = "R2 R3 code11";
      set_stop(3); prescale = 8'd1;
      send_byte(8'h96); wait_idle();
      chk(stop_code == 2'b11, "R3 code held", int'(stop_code), 3);

      // R4: back to back
      cur_req = "R4";
      set_stop(0);
      send_byte(8'h01); send_byte(8'h80); wait_idle();

      // R6 R7: break from idle
      cur_req = "R6 R7";
      step(); brk_set = 1'b1;
      step(); brk_set = 1'b0;
      @(negedge clk);
      chk(brk_busy == 1'b1, "R7 flag raised", int'(brk_busy), 1);
      chk(in_ready == 1'b0, "R4 no ready with break", int'(in_ready), 0);
      wait_idle();
      chk(brk_busy == 1'b0, "R7 flag cleared", int'(brk_busy), 0);
      chk(tx == 1'b1, "R6 line high after break", int'(tx), 1);
      repeat (50) step();
      @(negedge clk);
      chk(tx == 1'b1, "R7 no break with flag low", int'(tx), 1);

      // R8: break raised mid frame, byte waiting
      cur_req = "R8";
      send_byte(8'h11);
      in_valid = 1'b1; in_data = 8'h22;
      repeat (40) step();
      brk_set = 1'b1;
      step(); brk_set = 1'b0;
      waited = 0;
      @(negedge clk);
      while (!in_ready) begin @(negedge clk); waited++; end
      chk(brk_busy == 1'b0, "R8 break done before byte", int'(brk_busy), 0);
      chk(waited >= (144 + 16 + 16) * 2, "R8 break went first", waited, (144 + 16 + 16) * 2);
      step(); in_valid = 1'b0;
      wait_idle();

      // R9 R10: enable dropped mid frame, stop written during it
      cur_req = "R9 R10";
      send_byte(8'h5A);
      repeat (60) step();
      tx_en = 1'b0; stop_wr = 1'b1; stop_wdata = 2'b11; in_valid = 1'b1; in_data = 8'hFF;
      step(); stop_wr = 1'b0;
      wait_idle();
      repeat (30) step();
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 ready stays low", int'(in_ready), 0);
      chk(tx == 1'b1, "R9 line idle", int'(tx), 1);
      chk(stop_code == 2'b11, "R10 later write kept", int'(stop_code), 3);
      step(); in_valid = 1'b0; tx_en = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R9 ready back", int'(in_ready), 1);

      repeat (5) step();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule